// File: doc/BRIEF.md
# Software Write-Protect Command Sequencer

This block sits in front of the write path of a paged nonvolatile array. It watches every qualified byte write, which is a one-cycle strobe carrying an address and a data byte, and looks for fixed address/data key sequences. It keeps one software write-protect flag for each region of 2^REGION_AW bytes, so any mix of regions can be locked.

A three-write key turns protection on. Under protection, the same key also lets one page of data through. A six-write key turns protection off. After either key a page of up to PAGE_BYTES data bytes may follow to any address. The new protect value takes hold when the programming period closes, which is signalled by `prog_done_i`, even if no data byte was loaded. A write to a protected region that lacks the key is not stored. That write instead raises a dummy-busy request, so that the full programming time is still spent.

The protect flags model nonvolatile cells. The normal reset does not touch them. Only the factory-clear input returns them to the unprotected state the part ships in.

Top module: `swp_sequencer`

## Requirements
- R1: `factory_clr_i` sampled high clears every bit of `protect_o` at that clock edge. Asserting `rst_ni` (active low) returns every key detector to idle and leaves `protect_o` unchanged.
- R2: A write that is neither a key step nor page data, aimed at an unprotected region, gives `wr_allow_o`=1 and `dummy_busy_o`=0 in the same cycle. With `wr_valid_i` low, both outputs are 0.
- R3: A write that is neither a key step nor page data, aimed at a protected region, gives `wr_allow_o`=0 and `dummy_busy_o`=1 in the same cycle, and it does not change `protect_o`.
- R4: A write that advances or restarts a key sequence is never stored: `wr_allow_o`=0 and `dummy_busy_o`=0. The key steps are compared on the low 17 address bits and the 8 data bits. The opening step is data AA at 5555 and the second step is 55 at 2AAA (hex). After those two steps, A0 at 5555 arms protection or page authorization, and 80 at 5555 leads to the long form. The long form is AA at 5555, then 55 at 2AAA, then 20 at 5555, which arms protection removal.
- R5: After the three-write key (AA/5555, 55/2AAA, A0/5555), the next PAGE_BYTES (default 128) writes to that region are allowed whatever their address or data. Further writes before the window closes give `wr_allow_o`=0 and `dummy_busy_o`=0. On the first clock edge that samples `prog_done_i` while the window is open, that region's `protect_o` bit becomes 1.
- R6: A three-write key followed by no data still sets the region's protect bit at the next `prog_done_i`.
- R7: In a region that is already protected, the three-write key allows the page data that follows, and the region's protect bit stays 1.
- R8: The six-write key (AA/5555, 55/2AAA, 80/5555, AA/5555, 55/2AAA, 20/5555), followed by 0 to PAGE_BYTES data writes, clears that region's protect bit at the next `prog_done_i`.
- R9: A write that does not match the expected next step returns the detector to idle and is handled as an ordinary write (R2/R3). An AA/5555 write at any step outside the page window restarts the sequence at step one. The one exception is the step after 80/5555, where AA/5555 is the expected next step.
- R10: The region is chosen by the address bits above the low REGION_AW bits. A key step or page write affects only the detector and protect bit of the region it addresses.
- R11: `prog_done_i` has no effect on a region with no open page window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the key detectors |
| factory_clr_i | input | 1 | Synchronous clear of all protect flags |
| wr_valid_i | input | 1 | Qualified byte write strobe, one cycle per write |
| wr_addr_i | input | ADDR_W (19) | Write byte address; upper bits select the region |
| wr_data_i | input | 8 | Write data byte |
| prog_done_i | input | 1 | End of the current programming period |
| protect_o | output | NUM_REGIONS (4) | Per-region protect flag |
| wr_allow_o | output | 1 | This write may be stored in the array |
| dummy_busy_o | output | 1 | This write was swallowed; run a programming period that stores nothing |

## Verification
`wr_allow_o` and `dummy_busy_o` are combinational in the write cycle. They are due in the same cycle that `wr_valid_i` is high, and they depend on the detector state left by the previous edge. `protect_o` changes at the edge that samples `prog_done_i` or `factory_clr_i`, and it is first visible in the following cycle. The bench drives inputs just after the rising edge. A behavioural model tracks per-region step counters, window flags and byte counts. At each falling edge the bench compares all three outputs against that model, then advances the model to the state due at the next rising edge.

// File: rtl/swp_pkg.sv
package swp_pkg;
  localparam int KEY_AW = 17;
  localparam logic [KEY_AW-1:0] KEY_ADDR_HI = 17'h05555;
  localparam logic [KEY_AW-1:0] KEY_ADDR_LO = 17'h02AAA;
  localparam logic [7:0] KEY_OPEN   = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
  localparam logic [7:0] KEY_ARM    = 8'hA0;
  localparam logic [7:0] KEY_EXTEND = 8'h80;
  localparam logic [7:0] KEY_DROP   = 8'h20;

  typedef enum logic [2:0] {
    TK_NONE, TK_OPEN, TK_SECOND, TK_ARM, TK_EXTEND, TK_DROP
  } tok_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_P1, ST_P2, ST_X3, ST_X4, ST_X5, ST_WIN
  } seq_e;
endpackage

// File: rtl/swp_key_decode.sv
module swp_key_decode
  import swp_pkg::*;
#(
  parameter int AW = 17
) (
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output tok_e          tok_o
);
  logic at_hi, at_lo;

  assign at_hi = (addr_i == AW'(KEY_ADDR_HI));
  assign at_lo = (addr_i == AW'(KEY_ADDR_LO));

  always_comb begin
    tok_o = TK_NONE;
    if (at_hi) begin
      unique case (data_i)
        KEY_OPEN:   tok_o = TK_OPEN;
        KEY_ARM:    tok_o = TK_ARM;
        KEY_EXTEND: tok_o = TK_EXTEND;
        KEY_DROP:   tok_o = TK_DROP;
        default:    tok_o = TK_NONE;
      endcase
    end else if (at_lo && data_i == KEY_SECOND) begin
      tok_o = TK_SECOND;
    end
  end
endmodule

// File: rtl/swp_region_seq.sv
module swp_region_seq
  import swp_pkg::*;
#(
  parameter int PAGE_BYTES = 128,
  localparam int CNT_W = $clog2(PAGE_BYTES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic factory_clr_i,
  input  logic hit_i,
  input  tok_e tok_i,
  input  logic prog_done_i,
  output logic protect_o,
  output logic allow_o,
  output logic dummy_o
);
  seq_e             st_q, st_d;
  logic             en_q, en_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             prot_q;
  logic             cmd;
  logic             close;
  logic             room;

  assign room  = (cnt_q < CNT_W'(PAGE_BYTES));
  assign close = (st_q == ST_WIN) && prog_done_i;

  always_comb begin
    st_d  = st_q;
    en_d  = en_q;
    cnt_d = cnt_q;
    cmd   = 1'b0;
    if (hit_i && st_q != ST_WIN) begin
      cmd = 1'b1;
      unique case (st_q)
        ST_IDLE: if (tok_i == TK_OPEN) st_d = ST_P1;
                 else cmd = 1'b0;
        ST_P1:   if (tok_i == TK_SECOND) st_d = ST_P2;
                 else if (tok_i == TK_OPEN) st_d = ST_P1;
                 else begin st_d = ST_IDLE; cmd = 1'b0; end
        ST_P2:   if (tok_i == TK_ARM) begin
                   st_d = ST_WIN; en_d = 1'b1; cnt_d = '0;
                 end else if (tok_i == TK_EXTEND) st_d = ST_X3;
                 else if (tok_i == TK_OPEN) st_d = ST_P1;
                 else begin st_d = ST_IDLE; cmd = 1'b0; end
        ST_X3:   if (tok_i == TK_OPEN) st_d = ST_X4;
                 else begin st_d = ST_IDLE; cmd = 1'b0; end
        ST_X4:   if (tok_i == TK_SECOND) st_d = ST_X5;
                 else if (tok_i == TK_OPEN) st_d = ST_P1;
                 else begin st_d = ST_IDLE; cmd = 1'b0; end
        ST_X5:   if (tok_i == TK_DROP) begin
                   st_d = ST_WIN; en_d = 1'b0; cnt_d = '0;
                 end else if (tok_i == TK_OPEN) st_d = ST_P1;
                 else begin st_d = ST_IDLE; cmd = 1'b0; end
        default: begin st_d = ST_IDLE; cmd = 1'b0; end
      endcase
    end
    if (hit_i && st_q == ST_WIN && room) cnt_d = cnt_q + 1'b1;
    if (close) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
    end
  end

  always_comb begin
    allow_o = 1'b0;
    dummy_o = 1'b0;
    if (hit_i) begin
      if (st_q == ST_WIN) allow_o = room;
      else if (!cmd) begin
        allow_o = !prot_q;
        dummy_o = prot_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      en_q  <= en_d;
      cnt_q <= cnt_d;
    end
  end

  // nonvolatile cell: only the factory clear touches it, never rst_ni
  always_ff @(posedge clk_i) begin
    if (factory_clr_i) prot_q <= 1'b0;
    else if (close)    prot_q <= en_q;
  end

  assign protect_o = prot_q;
endmodule

// File: rtl/swp_sequencer.sv
module swp_sequencer
  import swp_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int REGION_AW   = 17,
  parameter int PAGE_BYTES  = 128,
  localparam int SEL_W  = $clog2(NUM_REGIONS),
  localparam int ADDR_W = REGION_AW + SEL_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   factory_clr_i,
  input  logic                   wr_valid_i,
  input  logic [ADDR_W-1:0]      wr_addr_i,
  input  logic [7:0]             wr_data_i,
  input  logic                   prog_done_i,
  output logic [NUM_REGIONS-1:0] protect_o,
  output logic                   wr_allow_o,
  output logic                   dummy_busy_o
);
  tok_e                   tok;
  logic [SEL_W-1:0]       sel;
  logic [NUM_REGIONS-1:0] hit, allow_v, dummy_v;

  assign sel = wr_addr_i[ADDR_W-1 -: SEL_W];

  swp_key_decode #(.AW(REGION_AW)) u_dec (
    .addr_i (wr_addr_i[REGION_AW-1:0]),
    .data_i (wr_data_i),
    .tok_o  (tok)
  );

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    assign hit[r] = wr_valid_i && (sel == SEL_W'(r));
    swp_region_seq #(.PAGE_BYTES(PAGE_BYTES)) u_seq (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .factory_clr_i (factory_clr_i),
      .hit_i         (hit[r]),
      .tok_i         (tok),
      .prog_done_i   (prog_done_i),
      .protect_o     (protect_o[r]),
      .allow_o       (allow_v[r]),
      .dummy_o       (dummy_v[r])
    );
  end

  assign wr_allow_o   = |allow_v;
  assign dummy_busy_o = |dummy_v;
endmodule

// File: rtl/swp_sequencer_chk.sv
module swp_sequencer_chk #(
  parameter int NUM_REGIONS = 4,
  parameter int ADDR_W      = 19,
  localparam int SEL_W = $clog2(NUM_REGIONS)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   factory_clr_i,
  input logic                   wr_valid_i,
  input logic [ADDR_W-1:0]      wr_addr_i,
  input logic                   prog_done_i,
  input logic [NUM_REGIONS-1:0] protect_o,
  input logic                   wr_allow_o,
  input logic                   dummy_busy_o
);
  logic             cleared_q;
  logic [SEL_W-1:0] sel;

  assign sel = wr_addr_i[ADDR_W-1 -: SEL_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cleared_q <= 1'b0;
    else if (factory_clr_i) cleared_q <= 1'b1;
  end

  // R1
  factory_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    factory_clr_i |=> protect_o == '0);

  // R11
  protect_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cleared_q && !factory_clr_i && !prog_done_i) |=> $stable(protect_o));

  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |-> (!wr_allow_o && !dummy_busy_o));

  // R3
  dummy_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cleared_q && dummy_busy_o) |-> (!wr_allow_o && protect_o[sel]));

  // R2
  unprot_no_dummy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cleared_q && wr_valid_i && !protect_o[sel]) |-> !dummy_busy_o);
endmodule

bind swp_sequencer swp_sequencer_chk #(
  .NUM_REGIONS (NUM_REGIONS),
  .ADDR_W      (ADDR_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .factory_clr_i (factory_clr_i),
  .wr_valid_i    (wr_valid_i),
  .wr_addr_i     (wr_addr_i),
  .prog_done_i   (prog_done_i),
  .protect_o     (protect_o),
  .wr_allow_o    (wr_allow_o),
  .dummy_busy_o  (dummy_busy_o)
);

// File: tb/swp_sequencer_test.sv
`timescale 1ns/1ps
module swp_sequencer_test;
  localparam int NR = 4;
  localparam int PAGE = 128;
  localparam int AW = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fclr = 1'b1;
  logic wv = 1'b0;
  logic [AW-1:0] wa = '0;
  logic [7:0] wd = '0;
  logic pd = 1'b0;
  logic [NR-1:0] prot;
  logic allow, dummy;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit finished = 0;

  int m_step [NR];
  bit m_win [NR];
  bit m_en [NR];
  int m_cnt [NR];
  bit m_prot [NR];
  bit prot_known = 0;

  swp_sequencer uut (
    .clk_i(clk), .rst_ni(rst_n), .factory_clr_i(fclr),
    .wr_valid_i(wv), .wr_addr_i(wa), .wr_data_i(wd), .prog_done_i(pd),
    .protect_o(prot), .wr_allow_o(allow), .dummy_busy_o(dummy)
  );

  always #5 clk = ~clk;

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  // 0 none,1 AA@5555,2 55@2AAA,3 A0@5555,4 80@5555,5 20@5555
  function automatic int tok_of(input logic [AW-1:0] a, input logic [7:0] d);
    if (a[16:0] == 17'h05555) begin
      if (d == 8'hAA) return 1;
      if (d == 8'hA0) return 3;
      if (d == 8'h80) return 4;
      if (d == 8'h20) return 5;
    end else if (a[16:0] == 17'h02AAA && d == 8'h55) return 2;
    return 0;
  endfunction

  always @(negedge clk) begin
    if (!finished) begin
      bit ea, ed, cmd;
      int r, t;
      bit old_win [NR];
      ea = 0; ed = 0;
      if (!rst_n) for (int i = 0; i < NR; i++) begin m_step[i] = 0; m_win[i] = 0; m_cnt[i] = 0; end
      for (int i = 0; i < NR; i++) old_win[i] = m_win[i];
      if (wv && rst_n) begin
        r = int'(wa[AW-1:17]);
        t = tok_of(wa, wd);
        if (m_win[r]) begin
          ea = (m_cnt[r] < PAGE);
          if (ea) m_cnt[r]++;
        end else begin
          cmd = 1;
          if (t == 1) m_step[r] = (m_step[r] == 3) ? 4 : 1;
          else if (m_step[r] == 1 && t == 2) m_step[r] = 2;
          else if (m_step[r] == 2 && t == 3) begin m_step[r] = 0; m_win[r] = 1; m_en[r] = 1; m_cnt[r] = 0; end
          else if (m_step[r] == 2 && t == 4) m_step[r] = 3;
          else if (m_step[r] == 4 && t == 2) m_step[r] = 5;
          else if (m_step[r] == 5 && t == 5) begin m_step[r] = 0; m_win[r] = 1; m_en[r] = 0; m_cnt[r] = 0; end
          else begin cmd = 0; m_step[r] = 0; end
          if (!cmd) begin ea = !m_prot[r]; ed = m_prot[r]; end
        end
      end
      chk("wr_allow_o", int'(allow), int'(ea));
      chk("dummy_busy_o", int'(dummy), int'(ed));
      if (prot_known)
        for (int i = 0; i < NR; i++) chk($sformatf("protect_o[%0d]", i), int'(prot[i]), int'(m_prot[i]));
      for (int i = 0; i < NR; i++) begin
        if (rst_n && pd && old_win[i]) begin
          m_prot[i] = m_en[i]; m_win[i] = 0; m_cnt[i] = 0;
        end
        if (fclr) m_prot[i] = 0;
      end
      if (fclr) prot_known = 1;
    end
  end

  task automatic step(input bit v, input logic [AW-1:0] a, input logic [7:0] d, input bit p);
    @(posedge clk); #1;
    wv = v; wa = a; wd = d; pd = p;
  endtask

  task automatic wr(input int reg_i, input int a, input logic [7:0] d);
    step(1, {2'(reg_i), 17'(a)}, d, 0);
  endtask

  task automatic idle();
    step(0, '0, '0, 0);
  endtask

  task automatic done();
    step(0, '0, '0, 1);
  endtask

  task automatic key3(input int reg_i);
    wr(reg_i, 'h5555, 8'hAA); wr(reg_i, 'h2AAA, 8'h55); wr(reg_i, 'h5555, 8'hA0);
  endtask

  initial begin
    int i;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1 fclr = 1'b0;
    idle();
    cur_req = "R1"; chk("protect_o after factory clear", int'(prot), 0);

    cur_req = "R2"; wr(0, 'h00010, 8'h12); wr(1, 'h1FFFF, 8'h34); idle();
    cur_req = "R4"; wr(0, 'h5555, 8'hAA); wr(0, 'h2AAA, 8'h55);
    cur_req = "R9"; wr(0, 'h00400, 8'h77); wr(0, 'h5555, 8'hA0); idle();

    cur_req = "R5"; key3(1);
    for (i = 0; i < 3; i++) wr(1, 'h00100 + i, 8'(i));
    idle(); done(); idle();
    chk("R5 protect_o[1] set", int'(prot[1]), 1);

    cur_req = "R3"; wr(1, 'h00020, 8'h99); wr(1, 'h5555, 8'hA0); idle();
    chk("R3 protect_o[1] kept", int'(prot[1]), 1);

    cur_req = "R7"; key3(1); wr(1, 'h00300, 8'h5A); wr(1, 'h00301, 8'hA5); done(); idle();
    wr(1, 'h00302, 8'h01);

    cur_req = "R5"; key3(2);
    for (i = 0; i < PAGE + 2; i++) wr(2, 'h05555, 8'hAA);
    done(); idle();

    cur_req = "R6"; key3(3); idle(); done(); idle();
    chk("R6 protect_o[3] set", int'(prot[3]), 1);

    cur_req = "R10"; wr(0, 'h5555, 8'hAA); wr(1, 'h2AAA, 8'h55); wr(0, 'h2AAA, 8'h55);
    wr(3, 'h5555, 8'hA0); wr(0, 'h5555, 8'hA0); wr(0, 'h00001, 8'h11); done(); idle();

    cur_req = "R11"; done(); done(); idle();

    cur_req = "R8";
    wr(1, 'h5555, 8'hAA); wr(1, 'h2AAA, 8'h55); wr(1, 'h5555, 8'h80);
    wr(1, 'h5555, 8'hAA); wr(1, 'h2AAA, 8'h55); wr(1, 'h5555, 8'h20);
    wr(1, 'h00040, 8'hC3); done(); idle();
    chk("R8 protect_o[1] cleared", int'(prot[1]), 0);
    wr(1, 'h00041, 8'h3C);

    cur_req = "R9"; wr(3, 'h5555, 8'hAA); wr(3, 'h5555, 8'hAA); wr(3, 'h2AAA, 8'h55);
    wr(3, 'h5555, 8'h80); wr(3, 'h2AAA, 8'h55); wr(3, 'h5555, 8'hAA); wr(3, 'h2AAA, 8'h55);
    wr(3, 'h5555, 8'hA0); wr(3, 'h00008, 8'h44); done(); idle();

    cur_req = "R1"; wr(2, 'h5555, 8'hAA); wr(2, 'h2AAA, 8'h55); idle();
    @(posedge clk); #1 rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    idle();
    chk("R1 protect_o kept over reset", int'(prot), 4'b1101);
    wr(2, 'h5555, 8'hA0); idle();
    @(posedge clk); #1 fclr = 1'b1;
    @(posedge clk); #1 fclr = 1'b0;
    idle();
    chk("R1 factory clear", int'(prot), 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL %s watchdog: actual timeout expected completion", cur_req);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule